// File: doc/BRIEF.md
# Debug Freeze Controller with Watchdog

This block holds the debug freeze bit that a monitor routine sets while it inspects a halted system. While the bit is set, the watchdog counter stops and keeps its count, peripherals that have opted in through a per-unit enable mask receive a freeze signal, and reads of read-to-clear status registers from the core become plain reads. These reads return data but clear no bits and send no acknowledge pulse. When the bit is cleared, everything resumes from where it stopped.

Some paths are not gated by the freeze bit. The non-maskable-interrupt status register always clears on read. Reads from the host-side port keep their side effects. Core reads routed through the host-register path also keep their side effects. A timeout already raised when the freeze takes effect still reaches the reset output.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: While `dbg_frozen` is 1 and no touch occurs, `wd_count` keeps its value. After the freeze bit is cleared, counting resumes from that held value.
- R2: If the count is zero at the clock edge where the freeze bit is written to 1, `wd_rst` is still 1 in the following cycle.
- R3: While `dbg_frozen` is 1, `wd_rst` is 0 in the next cycle.
- R4: `periph_frz[i]` is 1 exactly when mask bit i and the freeze bit are both 1. The mask bits are: bit 0 timer unit A, bit 1 timer unit B, bit 2 bus controller A, bit 3 bus controller B.
- R5: While frozen, a direct core read of the sample status register returns its bits. It leaves them set and gives no `stat_ack` pulse.
- R6: A core read of the NMI status register returns its bits and then clears them, with a one-cycle `nmi_ack` pulse, whether or not the block is frozen.
- R7: A host-port read of the sample status register, or a core read with `core_via_host` at 1, clears the register and pulses `stat_ack` even while frozen.
- R8: After reset the freeze bit, the mask and both status registers are 0. The period and `wd_count` equal `DEF_PERIOD`, and `wd_rst` is 0.
- R9: A touch reloads the count from the period register. A touch is a core write to word 3 or `wd_kick` at 1. Each unfrozen cycle without a touch decrements the count. One cycle after the count is zero, `wd_rst` is 1 for one cycle and the count equals the period again. The touch takes precedence even while frozen.
- R10: Word map: 0 control (freeze in bit 0), 1 freeze-enable mask, 2 watchdog period, 3 touch (reads 0), 4 sample status, 5 NMI status. All of these read back through `core_rdata`. `rd_sup` equals the freeze bit.
- R11: An event bit sets its status bit at the next edge. The status value is visible on the same cycle's read data. When an event and a clearing read meet at the same edge, the event bit survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_sel | input | 1 | Core register access strobe |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_via_host | input | 1 | Core access uses the host-register path |
| core_addr | input | 3 | Core word address |
| core_wdata | input | DW | Core write data |
| core_rdata | output | DW | Core read data, same cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host word address (4 and 5 answer) |
| host_rdata | output | DW | Host read data, same cycle |
| wd_kick | input | 1 | Watchdog touch pin |
| stat_evt | input | SW | Sample status set events |
| nmi_evt | input | SW | NMI status set events |
| dbg_frozen | output | 1 | Current freeze bit |
| periph_frz | output | NP | Per-peripheral freeze |
| rd_sup | output | 1 | Suppress read side effects for other status registers |
| wd_count | output | WDW | Watchdog count |
| wd_rst | output | 1 | Watchdog reset pulse |
| stat_ack | output | 1 | Sample status clear pulse |
| nmi_ack | output | 1 | NMI status clear pulse |

## Verification
Read data on both ports is combinational and is due in the cycle of the request. Register writes, count steps, status clears and the acknowledge pulses appear one edge later. `wd_rst` appears on the edge after the count was seen at zero. The bench drives every input at the falling edge and samples at the next falling edge, half a period after the edge that updates the state. Combinational read data is sampled 1 ns after the inputs are driven. A bench model of the counter is stepped from the same inputs and compared with `wd_count` and `wd_rst` every cycle. Period and mask sweeps cover every mask value and the periods 1 to 6.

// File: rtl/dfz_pkg.sv
// Shared constants for the debug freeze controller: address width and the
// word addresses of its registers. Assumes a word-addressed register port.
package dfz_pkg;
    localparam int unsigned AW = 3;
    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_FMASK = 3'd1;
    localparam logic [AW-1:0] A_WDPER = 3'd2;
    localparam logic [AW-1:0] A_KICK  = 3'd3;
    localparam logic [AW-1:0] A_STAT  = 3'd4;
    localparam logic [AW-1:0] A_NMI   = 3'd5;
endpackage

// File: rtl/dfz_ctrl_regs.sv
// Writable control state: freeze bit, per-peripheral enable mask and the
// watchdog period, plus a touch strobe decoded from a write to the touch word.
// Assumes one write per cycle; writes take effect at the next edge.
module dfz_ctrl_regs
    import dfz_pkg::*;
#(
    parameter int unsigned DW         = 16,
    parameter int unsigned WDW        = 16,
    parameter int unsigned NP         = 4,
    parameter int unsigned DEF_PERIOD = 255
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic           freeze_q,
    output logic [NP-1:0]  mask_q,
    output logic [WDW-1:0] period_q,
    output logic           kick_stb,
    output logic [NP-1:0]  periph_frz
);
    // Register updates from core writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            mask_q   <= '0;
            period_q <= WDW'(DEF_PERIOD);
        end else if (wr_en) begin
            if (wr_addr == A_CTRL)  freeze_q <= wr_data[0];
            if (wr_addr == A_FMASK) mask_q   <= wr_data[NP-1:0];
            if (wr_addr == A_WDPER) period_q <= wr_data[WDW-1:0];
        end
    end

    // Touch strobe for the watchdog.
    always_comb kick_stb = wr_en && (wr_addr == A_KICK);

    // One gated freeze output per peripheral.
    for (genvar i = 0; i < NP; i++) begin : g_frz
        assign periph_frz[i] = freeze_q & mask_q[i];
    end
endmodule

// File: rtl/dfz_wdog.sv
// Watchdog down-counter. Reloads on touch, holds while frozen, and on reaching
// zero emits a one-cycle reset pulse and reloads. The freeze value used at an
// edge is the one before that edge, so a timeout due at the edge that sets
// freeze still fires.
module dfz_wdog #(
    parameter int unsigned WDW        = 16,
    parameter int unsigned DEF_PERIOD = 255
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           freeze,
    input  logic           kick,
    input  logic [WDW-1:0] period,
    output logic [WDW-1:0] count,
    output logic           rst_pulse
);
    // Count, hold, reload and timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= WDW'(DEF_PERIOD);
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (kick) begin
                count <= period;
            end else if (!freeze) begin
                if (count == '0) begin
                    count     <= period;
                    rst_pulse <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dfz_rc_status.sv
// Read-to-clear status register. Events set bits; a clearing read zeroes them
// at the edge, with events of that same edge kept. EXEMPT selects whether the
// freeze bit may suppress core reads. Host reads and host-path core reads
// always clear.
module dfz_rc_status #(
    parameter int unsigned SW     = 8,
    parameter bit          EXEMPT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_evt,
    input  logic          rd_core,
    input  logic          core_bypass,
    input  logic          rd_host,
    input  logic          freeze,
    output logic [SW-1:0] status,
    output logic          ack
);
    logic clr;

    // Decide whether this cycle's read is destructive.
    if (EXEMPT) begin : g_exempt
        always_comb clr = rd_core | rd_host;
    end else begin : g_gated
        always_comb clr = rd_host | (rd_core & (core_bypass | ~freeze));
    end

    // Status bits and clear acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            ack    <= 1'b0;
        end else begin
            status <= (clr ? '0 : status) | set_evt;
            ack    <= clr;
        end
    end
endmodule

// File: rtl/dbg_freeze_ctrl.sv
// Debug freeze controller top. Joins the control registers, watchdog and two
// read-to-clear status registers (one exempt from freeze) and muxes the core
// and host read data. Assumes DW >= WDW, DW >= SW and DW >= NP.
module dbg_freeze_ctrl
    import dfz_pkg::*;
#(
    parameter int unsigned DW         = 16,
    parameter int unsigned WDW        = 16,
    parameter int unsigned SW         = 8,
    parameter int unsigned NP         = 4,
    parameter int unsigned DEF_PERIOD = 255
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           core_sel,
    input  logic           core_wr,
    input  logic           core_via_host,
    input  logic [AW-1:0]  core_addr,
    input  logic [DW-1:0]  core_wdata,
    output logic [DW-1:0]  core_rdata,
    input  logic           host_rd,
    input  logic [AW-1:0]  host_addr,
    output logic [DW-1:0]  host_rdata,
    input  logic           wd_kick,
    input  logic [SW-1:0]  stat_evt,
    input  logic [SW-1:0]  nmi_evt,
    output logic           dbg_frozen,
    output logic [NP-1:0]  periph_frz,
    output logic           rd_sup,
    output logic [WDW-1:0] wd_count,
    output logic           wd_rst,
    output logic           stat_ack,
    output logic           nmi_ack
);
    logic           wr_en, core_rd, kick_reg;
    logic [NP-1:0]  mask_q;
    logic [WDW-1:0] period_q;
    logic [SW-1:0]  stat_q, nmi_q;

    // Core access decode.
    always_comb begin
        wr_en   = core_sel & core_wr;
        core_rd = core_sel & ~core_wr;
    end

    dfz_ctrl_regs #(.DW(DW), .WDW(WDW), .NP(NP), .DEF_PERIOD(DEF_PERIOD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(core_addr),
        .wr_data(core_wdata), .freeze_q(dbg_frozen), .mask_q(mask_q),
        .period_q(period_q), .kick_stb(kick_reg), .periph_frz(periph_frz)
    );

    dfz_wdog #(.WDW(WDW), .DEF_PERIOD(DEF_PERIOD)) u_wdog (
        .clk(clk), .rst_n(rst_n), .freeze(dbg_frozen), .kick(kick_reg | wd_kick),
        .period(period_q), .count(wd_count), .rst_pulse(wd_rst)
    );

    dfz_rc_status #(.SW(SW), .EXEMPT(1'b0)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_evt(stat_evt),
        .rd_core(core_rd && core_addr == A_STAT), .core_bypass(core_via_host),
        .rd_host(host_rd && host_addr == A_STAT), .freeze(dbg_frozen),
        .status(stat_q), .ack(stat_ack)
    );

    dfz_rc_status #(.SW(SW), .EXEMPT(1'b1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .set_evt(nmi_evt),
        .rd_core(core_rd && core_addr == A_NMI), .core_bypass(core_via_host),
        .rd_host(host_rd && host_addr == A_NMI), .freeze(dbg_frozen),
        .status(nmi_q), .ack(nmi_ack)
    );

    // Suppress flag offered to other status registers.
    always_comb rd_sup = dbg_frozen;

    // Core read data mux.
    always_comb begin
        core_rdata = '0;
        case (core_addr)
            A_CTRL:  core_rdata[0]        = dbg_frozen;
            A_FMASK: core_rdata[NP-1:0]   = mask_q;
            A_WDPER: core_rdata[WDW-1:0]  = period_q;
            A_STAT:  core_rdata[SW-1:0]   = stat_q;
            A_NMI:   core_rdata[SW-1:0]   = nmi_q;
            default: core_rdata           = '0;
        endcase
    end

    // Host read data mux: status words only.
    always_comb begin
        host_rdata = '0;
        if (host_addr == A_STAT) host_rdata[SW-1:0] = stat_q;
        if (host_addr == A_NMI)  host_rdata[SW-1:0] = nmi_q;
    end
endmodule

// File: rtl/dfz_checker.sv
// Assertion checker for dbg_freeze_ctrl, attached by bind. Observes ports only.
module dfz_checker
    import dfz_pkg::*;
#(
    parameter int unsigned WDW = 16,
    parameter int unsigned NP  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           core_sel,
    input logic           core_wr,
    input logic           core_via_host,
    input logic [AW-1:0]  core_addr,
    input logic           host_rd,
    input logic [AW-1:0]  host_addr,
    input logic           wd_kick,
    input logic           dbg_frozen,
    input logic [NP-1:0]  periph_frz,
    input logic [WDW-1:0] wd_count,
    input logic           wd_rst,
    input logic           stat_ack,
    input logic           nmi_ack
);
    logic kick_now, host_stat;
    always_comb begin
        kick_now  = wd_kick || (core_sel && core_wr && core_addr == A_KICK);
        host_stat = host_rd && host_addr == A_STAT;
    end

    a_r1_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_frozen && !kick_now) |=> $stable(wd_count));

    a_r3_no_timeout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_frozen |=> !wd_rst);

    a_r4_frz_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_frz) |-> dbg_frozen);

    a_r5_frozen_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_frozen && core_sel && !core_wr && !core_via_host &&
         core_addr == A_STAT && !host_stat) |=> !stat_ack);

    a_r6_nmi_read_acts: assert property (@(posedge clk) disable iff (!rst_n)
        (core_sel && !core_wr && core_addr == A_NMI) |=> nmi_ack);

    a_r7_host_read_acts: assert property (@(posedge clk) disable iff (!rst_n)
        host_stat |=> stat_ack);
endmodule

bind dbg_freeze_ctrl dfz_checker #(.WDW(WDW), .NP(NP)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_sel(core_sel), .core_wr(core_wr),
    .core_via_host(core_via_host), .core_addr(core_addr), .host_rd(host_rd),
    .host_addr(host_addr), .wd_kick(wd_kick), .dbg_frozen(dbg_frozen),
    .periph_frz(periph_frz), .wd_count(wd_count), .wd_rst(wd_rst),
    .stat_ack(stat_ack), .nmi_ack(nmi_ack)
);

// File: tb/tb_dbg_freeze_ctrl.sv
module tb_dbg_freeze_ctrl;
    localparam int DEF = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_sel = 0, core_wr = 0, core_via_host = 0;
    logic [2:0]  core_addr = 0, host_addr = 0;
    logic [15:0] core_wdata = 0;
    logic [15:0] core_rdata, host_rdata;
    logic        host_rd = 0, wd_kick = 0;
    logic [7:0]  stat_evt = 0, nmi_evt = 0;
    logic        dbg_frozen, rd_sup, wd_rst, stat_ack, nmi_ack;
    logic [3:0]  periph_frz;
    logic [15:0] wd_count;

    int n_tests = 0, n_fail = 0;
    logic        m_frz = 0;
    logic        m_rst = 0;
    logic [15:0] m_per = 16'(DEF), m_cnt = 16'(DEF);

    dbg_freeze_ctrl dut (
        .clk(clk), .rst_n(rst_n), .core_sel(core_sel), .core_wr(core_wr),
        .core_via_host(core_via_host), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .host_rd(host_rd),
        .host_addr(host_addr), .host_rdata(host_rdata), .wd_kick(wd_kick),
        .stat_evt(stat_evt), .nmi_evt(nmi_evt), .dbg_frozen(dbg_frozen),
        .periph_frz(periph_frz), .rd_sup(rd_sup), .wd_count(wd_count),
        .wd_rst(wd_rst), .stat_ack(stat_ack), .nmi_ack(nmi_ack)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: step the counter model from current inputs, then compare.
    task automatic cyc();
        logic        kick, wr;
        logic        n_frz, n_rst;
        logic [15:0] n_per, n_cnt;
        wr    = core_sel && core_wr;
        kick  = wd_kick || (wr && core_addr == 3'd3);
        n_frz = (wr && core_addr == 3'd0) ? core_wdata[0] : m_frz;
        n_per = (wr && core_addr == 3'd2) ? core_wdata : m_per;
        n_rst = 1'b0;
        n_cnt = m_cnt;
        if (kick) n_cnt = m_per;
        else if (!m_frz) begin
            if (m_cnt == 0) begin n_cnt = m_per; n_rst = 1'b1; end
            else n_cnt = m_cnt - 1;
        end
        if (!rst_n) begin
            n_frz = 0; n_per = 16'(DEF); n_cnt = 16'(DEF); n_rst = 0;
        end
        @(negedge clk);
        m_frz = n_frz; m_per = n_per; m_cnt = n_cnt; m_rst = n_rst;
        if (rst_n) begin
            chk(wd_count == m_cnt, m_frz ? "R1 count" : "R9 count", wd_count, m_cnt);
            chk(wd_rst == m_rst, m_frz ? "R3 wd_rst" : "R9 wd_rst", wd_rst, m_rst);
        end
    endtask

    task automatic idle(); cyc(); endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        core_sel = 1; core_wr = 1; core_addr = a; core_wdata = d;
        cyc();
        core_sel = 0; core_wr = 0; core_wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic via, output logic [15:0] v);
        core_sel = 1; core_wr = 0; core_addr = a; core_via_host = via;
        #1 v = core_rdata;
        cyc();
        core_sel = 0; core_via_host = 0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [15:0] v);
        host_rd = 1; host_addr = a;
        #1 v = host_rdata;
        cyc();
        host_rd = 0;
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int pulses;
        repeat (3) cyc();
        rst_n = 1;
        idle();
        // R8 reset state
        chk(dbg_frozen == 0, "R8 frozen", dbg_frozen, 0);
        chk(periph_frz == 0, "R8 periph", periph_frz, 0);
        chk(wd_count <= DEF, "R8 count", wd_count, DEF - 1);
        rd(3'd0, 0, v); chk(v == 0, "R8 ctrl", v, 0);
        rd(3'd1, 0, v); chk(v == 0, "R8 mask", v, 0);
        rd(3'd2, 0, v); chk(v == DEF, "R8 period", v, DEF);
        rd(3'd4, 0, v); chk(v == 0, "R8 stat", v, 0);
        rd(3'd5, 0, v); chk(v == 0, "R8 nmi", v, 0);

        // R4 / R10 mask and freeze sweep
        for (int f = 0; f < 2; f++) begin
            for (int m = 0; m < 16; m++) begin
                wr(3'd1, 16'(m));
                wr(3'd0, 16'(f));
                chk(periph_frz == (f != 0 ? 4'(m) : 4'd0), "R4 periph_frz", periph_frz, f != 0 ? m : 0);
                chk(rd_sup == f[0], "R10 rd_sup", rd_sup, f);
                rd(3'd0, 0, v); chk(v == 16'(f), "R10 ctrl readback", v, f);
                rd(3'd1, 0, v); chk(v == 16'(m), "R10 mask readback", v, m);
            end
        end
        wr(3'd0, 0);
        wr(3'd1, 0);

        // R9 period sweep: pulse one cycle after zero, count reloaded
        for (int p = 1; p <= 6; p++) begin
            wr(3'd2, 16'(p));
            rd(3'd2, 0, v); chk(v == 16'(p), "R10 period readback", v, p);
            wr(3'd3, 0);
            chk(wd_count == 16'(p), "R9 reload", wd_count, p);
            pulses = 0;
            for (int k = 1; k <= p + 2; k++) begin
                idle();
                if (wd_rst) pulses++;
                chk(wd_rst == (k == p + 1), "R9 pulse position", wd_rst, k == p + 1);
            end
            chk(pulses == 1, "R9 single pulse", pulses, 1);
        end
        // R9 touch pin
        wr(3'd2, 16'd9);
        wd_kick = 1; idle(); wd_kick = 0;
        chk(wd_count == 9, "R9 kick pin", wd_count, 9);

        // R1 hold and resume
        wr(3'd2, 16'd10);
        wr(3'd3, 0);
        repeat (3) idle();
        wr(3'd0, 1);
        chk(wd_count == 6, "R1 freeze edge", wd_count, 6);
        pulses = 0;
        repeat (20) begin idle(); if (wd_rst) pulses++; end
        chk(wd_count == 6, "R1 held", wd_count, 6);
        chk(pulses == 0, "R3 no timeout", pulses, 0);
        wr(3'd0, 0);
        chk(wd_count == 6, "R1 unfreeze edge", wd_count, 6);
        idle();
        chk(wd_count == 5, "R1 resume", wd_count, 5);

        // R3 freeze near zero: no pulse
        wr(3'd2, 16'd3);
        wr(3'd3, 0);
        repeat (2) idle();
        wr(3'd0, 1);
        pulses = 0;
        repeat (10) begin idle(); if (wd_rst) pulses++; end
        chk(pulses == 0, "R3 frozen at 0", pulses, 0);
        chk(wd_count == 0, "R1 held at 0", wd_count, 0);
        // R9 touch while frozen
        wr(3'd3, 0);
        chk(wd_count == 3, "R9 touch while frozen", wd_count, 3);
        wr(3'd0, 0);

        // R2 timeout due at the freeze edge still fires
        wr(3'd2, 16'd4);
        wr(3'd3, 0);
        repeat (4) idle();
        chk(wd_count == 0, "R2 at zero", wd_count, 0);
        wr(3'd0, 1);
        chk(wd_rst == 1, "R2 pending reset", wd_rst, 1);
        chk(dbg_frozen == 1, "R2 frozen", dbg_frozen, 1);
        idle();
        chk(wd_rst == 0, "R3 after pending", wd_rst, 0);
        wr(3'd0, 0);

        // R11 status set and normal clear
        stat_evt = 8'h05; idle(); stat_evt = 0;
        rd(3'd4, 0, v); chk(v == 16'h05, "R11 status set", v, 5);
        chk(stat_ack == 1, "R11 ack unfrozen", stat_ack, 1);
        rd(3'd4, 0, v); chk(v == 0, "R11 cleared", v, 0);

        // R5 frozen core read is plain
        wr(3'd0, 1);
        stat_evt = 8'h30; idle(); stat_evt = 0;
        rd(3'd4, 0, v); chk(v == 16'h30, "R5 data", v, 16'h30);
        chk(stat_ack == 0, "R5 no ack", stat_ack, 0);
        rd(3'd4, 0, v); chk(v == 16'h30, "R5 not cleared", v, 16'h30);

        // R7 host-path core read and host read still clear
        rd(3'd4, 1, v); chk(v == 16'h30, "R7 via host data", v, 16'h30);
        chk(stat_ack == 1, "R7 via host ack", stat_ack, 1);
        rd(3'd4, 0, v); chk(v == 0, "R7 via host cleared", v, 0);
        stat_evt = 8'h0C; idle(); stat_evt = 0;
        hrd(3'd4, v); chk(v == 16'h0C, "R7 host data", v, 16'h0C);
        chk(stat_ack == 1, "R7 host ack", stat_ack, 1);
        rd(3'd4, 0, v); chk(v == 0, "R7 host cleared", v, 0);

        // R6 NMI status exempt, frozen and unfrozen
        nmi_evt = 8'h81; idle(); nmi_evt = 0;
        rd(3'd5, 0, v); chk(v == 16'h81, "R6 frozen data", v, 16'h81);
        chk(nmi_ack == 1, "R6 frozen ack", nmi_ack, 1);
        rd(3'd5, 0, v); chk(v == 0, "R6 frozen cleared", v, 0);
        wr(3'd0, 0);
        nmi_evt = 8'h42; idle(); nmi_evt = 0;
        rd(3'd5, 0, v); chk(v == 16'h42, "R6 data", v, 16'h42);
        rd(3'd5, 0, v); chk(v == 0, "R6 cleared", v, 0);

        // R11 event wins over same-edge clear
        stat_evt = 8'h01; idle();
        stat_evt = 8'h02;
        rd(3'd4, 0, v); stat_evt = 0;
        chk(v == 16'h01, "R11 before", v, 1);
        rd(3'd4, 0, v); chk(v == 16'h02, "R11 event kept", v, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule